// File: doc/BRIEF.md
# Split 64-bit Register Bridge

This block puts a small bank of 64-bit registers behind a 32-bit register port. Every 64-bit register takes two neighbouring word addresses. The word at the lower address holds bits 63:32. The word four bytes above it holds bits 31:0. Register index 0 is a writable control register. Indices 1 to NUM_CNT are free-running 64-bit event counters, and each counter advances on its own increment input.

A write to the lower word only loads a staging register. A write to the upper word moves the full 64 bits into the control register in one clock. Because of this, software that writes the words in ascending order never exposes a half-updated value.

Reads use the reverse approach. When either half of a counter is read, the other half is copied into a per-counter snapshot. A following read of the companion half returns that copy, so a two-access read of a running counter is coherent. One bit of the control word asks for a counter reset. That bit clears itself.

Top module: `wide_reg_bridge`

## Requirements
- R1: Register k sits at byte address 8*k. The word at 8*k returns bits 63:32, and the word at 8*k+4 returns bits 31:0. Index 0 is the control register, and indices 1..NUM_CNT are counters 0..NUM_CNT-1. After reset, the control register and all counters read zero.
- R2: A write to byte address 0x00 only stages 32 bits. `ctrl_value` does not change.
- R3: A write to byte address 0x04 loads {staged word, write data} into the control register. The new value appears on `ctrl_value` in the clock after the write.
- R4: The staged word is zero after reset and is kept after a commit. A lone write to 0x04 with nothing staged therefore gives an upper half of zero, and a second lone write reuses the earlier staged word.
- R5: Bit 31 of the word written to 0x04 is a reset request and is never stored. It reads back as 0. In the same clock as the commit, it clears every counter and drops every held snapshot. The clear wins over any increment in that clock.
- R6: Bits 30 and 29 of the low control word are plain storage and read back as written.
- R7: While its increment input is high, a counter gains one on each clock.
- R8: Reading one half of a counter returns the live half and captures the other half. A later read of the other half returns the captured value, even if the counter has moved in the meantime.
- R9: Reading the companion half consumes the snapshot. The next read of either half is again a first-half read of live data.
- R10: Counting never stalls while a snapshot is held.
- R11: Reading the same half again while a snapshot is held replaces the snapshot with the current value.
- R12: Some accesses are void: word indices above NUM_CNT, addresses with bits 1:0 not zero, and writes to counter addresses. Void reads return zero, and void writes change nothing.
- R13: A read request gives `bus_rvld` high with its data in the next clock. When no read was made in the previous clock, `bus_rvld` is low and `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| cnt_inc | input | NUM_CNT | One increment strobe per counter |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvld | output | 1 | Read data valid |
| ctrl_value | output | 64 | Current control register contents |

## Verification
Two functions can land in the same clock. A reset-request commit can meet active increments, and a snapshot read can meet a counter step.

The bench holds every increment high across the commit write. It then checks that the counters restart from zero and that a snapshot captured before the reset is not returned afterwards.

For coherence, the bench keeps increments running between the two half reads. It expects the captured value from the first read's clock, not the live value.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
    localparam int HALF_W = 32;
    localparam int REG_W  = 2 * HALF_W;
    localparam int RST_BIT = HALF_W - 1;

    typedef struct packed {
        logic [REG_W-1:0]  cnt;
        logic [HALF_W-1:0] snap;
        logic              snap_lo;
        logic              snap_vld;
    } cnt_state_t;

    typedef struct packed {
        logic [HALF_W-1:0] stage;
        logic [REG_W-1:0]  ctrl;
        logic [HALF_W-1:0] rdata;
        logic              rvld;
    } brg_state_t;
endpackage

// File: rtl/bridge_decode.sv
module bridge_decode #(
    parameter int ADDR_W   = 8,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              mapped,
    output logic              lo_word,
    output logic [ADDR_W-4:0] idx
);
    localparam int IDX_W = ADDR_W - 3;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    always_comb begin
        idx     = addr[ADDR_W-1:3];
        lo_word = addr[2];
        mapped  = (addr[1:0] == 2'b00) && (idx <= LAST);
    end
endmodule

// File: rtl/bridge_counter.sv
module bridge_counter
    import bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    input  logic              rd_en,
    input  logic              rd_lo,
    output logic [HALF_W-1:0] rd_data
);
    cnt_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        rd_data = '0;
        if (clr) begin
            s_d.cnt      = '0;
            s_d.snap_vld = 1'b0;
        end else begin
            if (inc) s_d.cnt = s_q.cnt + REG_W'(1);
            if (rd_en) begin
                if (s_q.snap_vld && (s_q.snap_lo == rd_lo)) begin
                    rd_data      = s_q.snap;
                    s_d.snap_vld = 1'b0;
                end else begin
                    rd_data      = rd_lo ? s_q.cnt[HALF_W-1:0] : s_q.cnt[REG_W-1:HALF_W];
                    s_d.snap     = rd_lo ? s_q.cnt[REG_W-1:HALF_W] : s_q.cnt[HALF_W-1:0];
                    s_d.snap_lo  = !rd_lo;
                    s_d.snap_vld = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wide_reg_bridge.sv
module wide_reg_bridge
    import bridge_pkg::*;
#(
    parameter int NUM_CNT = 3,
    parameter int ADDR_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_vld,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    input  logic [NUM_CNT-1:0] cnt_inc,
    output logic [31:0]        bus_rdata,
    output logic               bus_rvld,
    output logic [63:0]        ctrl_value
);
    localparam int NUM_REGS = NUM_CNT + 1;
    localparam int IDX_W    = ADDR_W - 3;

    logic              mapped, lo_word;
    logic [IDX_W-1:0]  idx;
    logic              is_rd, ctrl_hit, commit, clr_req;
    logic [HALF_W-1:0] cnt_rd [NUM_CNT];
    logic [HALF_W-1:0] rd_mux;
    brg_state_t        s_d, s_q;

    bridge_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_dec (
        .addr    (bus_addr),
        .mapped  (mapped),
        .lo_word (lo_word),
        .idx     (idx)
    );

    assign is_rd    = bus_vld && !bus_wr;
    assign ctrl_hit = bus_vld && bus_wr && mapped && (idx == '0);
    assign commit   = ctrl_hit && lo_word;
    assign clr_req  = commit && bus_wdata[RST_BIT];

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        bridge_counter u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .inc     (cnt_inc[g]),
            .clr     (clr_req),
            .rd_en   (is_rd && mapped && (idx == IDX_W'(g + 1))),
            .rd_lo   (lo_word),
            .rd_data (cnt_rd[g])
        );
    end

    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            if (idx == '0) begin
                rd_mux = lo_word ? s_q.ctrl[HALF_W-1:0] : s_q.ctrl[REG_W-1:HALF_W];
            end
            for (int i = 0; i < NUM_CNT; i++) begin
                if (idx == IDX_W'(i + 1)) rd_mux = cnt_rd[i];
            end
        end
    end

    always_comb begin
        s_d       = s_q;
        s_d.rvld  = is_rd;
        s_d.rdata = is_rd ? rd_mux : '0;
        if (ctrl_hit && !lo_word) s_d.stage = bus_wdata;
        if (commit) s_d.ctrl = {s_q.stage, 1'b0, bus_wdata[RST_BIT-1:0]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bus_rdata  = s_q.rdata;
    assign bus_rvld   = s_q.rvld;
    assign ctrl_value = s_q.ctrl;
endmodule

// File: rtl/wide_reg_bridge_chk.sv
module wide_reg_bridge_chk #(
    parameter int NUM_CNT = 3,
    parameter int ADDR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_vld,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              bus_rvld,
    input logic [63:0]       ctrl_value
);
    localparam int IDX_W = ADDR_W - 3;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_CNT);
    localparam logic [31:0] RST_MASK = 32'h8000_0000;

    logic wr_stage, wr_commit, rd_void;
    assign wr_stage  = bus_vld && bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_commit = bus_vld && bus_wr && (bus_addr == ADDR_W'(4));
    assign rd_void   = bus_vld && !bus_wr &&
                       ((bus_addr[1:0] != 2'b00) || (bus_addr[ADDR_W-1:3] > LAST));

    // R2
    stage_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stage |=> $stable(ctrl_value));

    // R3
    commit_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |=> (ctrl_value[31:0] == ($past(bus_wdata) & ~RST_MASK)));

    // R5
    rst_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_value[31]);

    // R13
    rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_vld && !bus_wr) |=> bus_rvld);

    // R13
    idle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_vld && !bus_wr) |=> (!bus_rvld && (bus_rdata == 32'h0)));

    // R12
    void_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_void |=> (bus_rdata == 32'h0));
endmodule

bind wide_reg_bridge wide_reg_bridge_chk #(.NUM_CNT(NUM_CNT), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_vld    (bus_vld),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .bus_rvld   (bus_rvld),
    .ctrl_value (ctrl_value)
);

// File: tb/sim_wide_reg_bridge.sv
`timescale 1ns/1ps
module sim_wide_reg_bridge;
    localparam int NC = 3;
    localparam int NV = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_vld = 1'b0, bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [NC-1:0] cnt_inc = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvld;
    logic [63:0]   ctrl_value;

    int n_chk = 0, n_bad = 0;
    logic done = 1'b0;
    logic [63:0] mdl [NC];
    logic [63:0] pre [NC];

    always #2 clk = ~clk;

    wide_reg_bridge #(.NUM_CNT(NC), .ADDR_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt_inc(cnt_inc),
        .bus_rdata(bus_rdata), .bus_rvld(bus_rvld), .ctrl_value(ctrl_value)
    );

    // {wr, addr, wdata, check, expected}
    localparam logic [73:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h0,         1'b1, 32'h0},          // R1 reset hi
        {1'b0, 8'h04, 32'h0,         1'b1, 32'h0},          // R1 reset lo
        {1'b1, 8'h00, 32'hA5A5_0001, 1'b0, 32'h0},          // stage
        {1'b0, 8'h00, 32'h0,         1'b1, 32'h0},          // R2
        {1'b1, 8'h04, 32'h6000_1234, 1'b0, 32'h0},          // commit
        {1'b0, 8'h00, 32'h0,         1'b1, 32'hA5A5_0001},  // R3
        {1'b0, 8'h04, 32'h0,         1'b1, 32'h6000_1234},  // R6
        {1'b1, 8'h04, 32'h0000_0042, 1'b0, 32'h0},          // R4 lone commit
        {1'b0, 8'h00, 32'h0,         1'b1, 32'hA5A5_0001},  // R4
        {1'b0, 8'h04, 32'h0,         1'b1, 32'h0000_0042},  // R4
        {1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0, 32'h0},          // void write
        {1'b0, 8'h20, 32'h0,         1'b1, 32'h0},          // R12
        {1'b0, 8'h3C, 32'h0,         1'b1, 32'h0},          // R12
        {1'b1, 8'h08, 32'h0000_1234, 1'b0, 32'h0},          // counter write
        {1'b0, 8'h08, 32'h0,         1'b1, 32'h0},          // R12
        {1'b0, 8'h06, 32'h0,         1'b1, 32'h0},          // R12 misaligned
        {1'b0, 8'h00, 32'h0,         1'b1, 32'hA5A5_0001}   // R12 ctrl intact
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic w, input logic [7:0] a,
                        input logic [31:0] d, input logic [NC-1:0] inc,
                        output logic [31:0] rd, output logic rv);
        bus_vld = v; bus_wr = w; bus_addr = a; bus_wdata = d; cnt_inc = inc;
        for (int i = 0; i < NC; i++) pre[i] = mdl[i];
        @(negedge clk);
        rd = bus_rdata; rv = bus_rvld;
        bus_vld = 1'b0; cnt_inc = '0;
        for (int i = 0; i < NC; i++) begin
            if (v && w && a == 8'h04 && d[31]) mdl[i] = '0;
            else mdl[i] = mdl[i] + 64'(inc[i]);
        end
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [NC-1:0] inc,
                          input logic [31:0] exp);
        logic [31:0] rd; logic rv;
        step(1'b1, 1'b0, a, 32'h0, inc, rd, rv);
        check(req, {31'h0, rv, rd}, {31'h0, 1'b1, exp});
    endtask

    task automatic idle(input int n, input logic [NC-1:0] inc);
        logic [31:0] rd; logic rv;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h0, 32'h0, inc, rd, rv);
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        logic [31:0] rd; logic rv;
        logic [63:0] snap_a;
        for (int i = 0; i < NC; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        check("R1 reset ctrl_value", ctrl_value, 64'h0);
        check("R13 reset rvld", {63'h0, bus_rvld}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            step(1'b1, VEC[k][73], VEC[k][72:65], VEC[k][64:33], '0, rd, rv);
            if (VEC[k][32]) check($sformatf("R1-table row %0d", k), {31'h0, rv, rd},
                                  {31'h0, 1'b1, VEC[k][31:0]});
        end
        check("R2 R3 ctrl_value", ctrl_value, 64'hA5A5_0001_0000_0042);

        // R13 idle cycle returns nothing
        step(1'b0, 1'b0, 8'h0, 32'h0, '0, rd, rv);
        check("R13 idle", {31'h0, rv, rd}, 64'h0);

        // R7 counter 0 counts 5
        idle(5, 3'b001);
        rd_chk("R7 cnt0 hi", 8'h08, '0, 32'h0);
        rd_chk("R7 cnt0 lo", 8'h0C, '0, 32'd5);

        // R8 R10 coherent read of counter 1 while counting
        idle(3, 3'b010);
        rd_chk("R8 cnt1 hi live", 8'h10, 3'b010, pre[1][63:32]);
        snap_a = pre[1];
        idle(4, 3'b010);
        rd_chk("R8 cnt1 lo snapshot", 8'h14, 3'b010, snap_a[31:0]);
        check("R10 counting during snapshot", mdl[1], 64'd9);
        // R9 snapshot consumed, next read is live
        rd_chk("R9 cnt1 lo live", 8'h14, '0, 32'd9);
        rd_chk("R9 cnt1 hi from snapshot", 8'h10, '0, 32'h0);

        // R11 repeated first-half read refreshes snapshot
        idle(2, 3'b100);
        rd_chk("R11 cnt2 hi first", 8'h18, 3'b100, 32'h0);
        idle(3, 3'b100);
        rd_chk("R11 cnt2 hi again", 8'h18, 3'b100, 32'h0);
        snap_a = pre[2];
        idle(2, 3'b100);
        rd_chk("R11 cnt2 lo refreshed", 8'h1C, '0, snap_a[31:0]);

        // R5 reset request with increments in the same cycle
        idle(4, 3'b111);
        rd_chk("R5 cnt2 hi before clear", 8'h18, 3'b111, 32'h0);
        step(1'b1, 1'b1, 8'h04, 32'h8000_0000, 3'b111, rd, rv);
        check("R5 ctrl_value self-clear", ctrl_value, 64'hA5A5_0001_0000_0000);
        idle(2, 3'b111);
        rd_chk("R5 cnt2 lo after clear", 8'h1C, '0, 32'd2);
        rd_chk("R5 cnt0 hi after clear", 8'h08, '0, 32'h0);
        rd_chk("R5 cnt0 lo after clear", 8'h0C, '0, 32'd2);
        rd_chk("R5 ctrl lo reads 0", 8'h04, '0, 32'h0);

        // R4 staged word is zero after reset
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 second reset ctrl_value", ctrl_value, 64'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NC; i++) mdl[i] = '0;
        @(negedge clk);
        step(1'b1, 1'b1, 8'h04, 32'h0000_0007, '0, rd, rv);
        check("R4 lone commit after reset", ctrl_value, 64'h7);
        rd_chk("R1 cnt1 zero after reset", 8'h14, '0, 32'h0);

        summary();
    end
endmodule